// File: doc/BRIEF.md
# Program Counter and Return Stack

This block keeps the instruction address of a small microcontroller core, which uses 14-bit instructions, together with the stack of return addresses for that core. The address is 10 bits wide and covers 1K words of program memory. The register advances by one in each instruction cycle that the core enables. The instruction decoder can also load it in three other ways:
- a long jump or long call puts the 10-bit target from the instruction immediate field into the counter;
- a software write to the low counter register takes its low eight bits from the ALU result and its two upper bits from a separately written high-byte latch;
- any of the three return kinds (return with value, plain return, return from interrupt) restores the counter from the stack.

A long call first saves the address that follows it (counter plus one) on an 8-level stack. That stack is circular. A ninth call silently replaces the oldest saved entry, and a return from an empty stack simply wraps the pointer. A return from interrupt also produces a one-cycle pulse that lets the core turn global interrupts back on. The register port decodes two addresses. 02h is the low counter byte and 0Ah is the high-byte latch. A read of the latch gives back the last byte written to it, not the current upper counter bits.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0, the stack pointer is at its start position, every stack entry and the high latch are 0, and `gie_set` is 0.
- R2: On a clock edge with `cyc_en` high and no load source active, `pc` becomes `pc+1`. With `cyc_en` low, `pc`, the stack and the latch keep their values.
- R3: On an enabled edge with `op_ljump` high, `pc` takes `imm_addr`.
- R4: On an enabled edge with `op_lcall` high, `pc+1` (modulo 1024) is pushed on the stack and `pc` takes `imm_addr`.
- R5: On an enabled edge with `reg_we` high and `reg_waddr` = 02h, `pc` becomes {latch[1:0], `alu_res`}. The latch value used is the one held before that edge.
- R6: On an enabled edge with `reg_we` high and `reg_waddr` = 0Ah, the latch stores `alu_res`. `reg_rdata` is `pc[7:0]` for `reg_raddr` = 02h, the stored latch byte for 0Ah, and 0 for any other address.
- R7: On an enabled edge with any of `op_retw`, `op_ret` or `op_reti` high, `pc` takes the most recently pushed entry that has not yet been popped (last in, first out).
- R8: `gie_set` is high for exactly the one cycle that follows an enabled edge with `op_reti` high, and is low at all other times.
- R9: The stack has 8 entries used as a ring. A push after 8 pushes overwrites the oldest entry. A pop moves the pointer back modulo 8 with no error indication.
- R10: When several sources are active on one enabled edge, the priority is: return, long call, long jump, low-register write, increment. Only the winning source changes `pc` or the stack. A latch write still takes effect.
- R11: Incrementing from 3FFh gives 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; all updates occur only when high |
| op_ljump | input | 1 | Long jump strobe |
| op_lcall | input | 1 | Long call strobe |
| op_retw | input | 1 | Return-with-value strobe |
| op_ret | input | 1 | Plain return strobe |
| op_reti | input | 1 | Return-from-interrupt strobe |
| imm_addr | input | 10 | Jump or call target from the instruction word |
| alu_res | input | 8 | ALU result bus, the register write data |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write address |
| reg_raddr | input | 8 | Register read address |
| pc | output | 10 | Current program counter |
| reg_rdata | output | 8 | Register read data |
| gie_set | output | 1 | One-cycle pulse that re-enables global interrupts |

## Verification
The assertions assume that every strobe and data input holds a known 0 or 1 value at each clock edge. They also assume that software writes reach the block only through the one write port, so the low register and the latch can never both be written on the same edge. Nothing has to be one-hot, because the priority order decides any collision. The random stimulus keeps within these rules: it picks a single write address per cycle, but it often raises several control strobes together and sometimes leaves `cyc_en` low. This covers the priority and hold behaviour as well as the single-source paths. Directed sequences of nine nested calls followed by nine returns, and a walk of the counter across 3FFh, reach the ring overwrite and the counter wrap.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PC_W  = 10;
  localparam int LO_W  = 8;
  localparam int HI_W  = PC_W - LO_W;
  localparam int DEPTH = 8;
  localparam int RA_W  = 8;

  typedef enum logic [2:0] {
    SEL_HOLD, SEL_INC, SEL_POP, SEL_CALL, SEL_JUMP, SEL_LOWWR
  } pc_sel_e;

  // sequential successor, wraps at the top of program space
  function automatic logic [PC_W-1:0] next_seq(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  // software write: upper bits from the latch, lower bits from the ALU
  function automatic logic [PC_W-1:0] join_low(input logic [HI_W-1:0] h,
                                               input logic [LO_W-1:0] l);
    return {h, l};
  endfunction
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int W     = pcs_pkg::PC_W,
  parameter int DEPTH = pcs_pkg::DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     ent [DEPTH];
  logic [PTR_W-1:0] sp;          // next free slot
  logic [PTR_W-1:0] rd_ptr;

  assign rd_ptr   = sp - PTR_W'(1);
  assign top_data = ent[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push) begin
      ent[sp] <= push_data;
      sp      <= sp + PTR_W'(1);
    end else if (pop) begin
      sp      <= rd_ptr;
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop}));
  p_push_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == $past(sp) + PTR_W'(1));
  p_pop_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == $past(sp) - PTR_W'(1));
  p_push_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_data == $past(push_data));
endmodule

// File: rtl/pcs_regport.sv
module pcs_regport #(
  parameter int                 RA_W    = pcs_pkg::RA_W,
  parameter int                 LO_W    = pcs_pkg::LO_W,
  parameter logic [RA_W-1:0]    LO_ADDR = 8'h02,
  parameter logic [RA_W-1:0]    HI_ADDR = 8'h0A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_waddr,
  input  logic [LO_W-1:0] wdata,
  input  logic [RA_W-1:0] reg_raddr,
  input  logic [LO_W-1:0] pc_low,
  output logic [LO_W-1:0] latch_q,
  output logic            lowwr_ev,
  output logic [LO_W-1:0] reg_rdata
);
  logic hiwr_ev;

  assign hiwr_ev  = cyc_en && reg_we && (reg_waddr == HI_ADDR);
  assign lowwr_ev = cyc_en && reg_we && (reg_waddr == LO_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (hiwr_ev) latch_q <= wdata;
  end

  always_comb begin
    if (reg_raddr == LO_ADDR)      reg_rdata = pc_low;
    else if (reg_raddr == HI_ADDR) reg_rdata = latch_q;
    else                           reg_rdata = '0;
  end

  p_latch_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hiwr_ev |=> $stable(latch_q));
  p_latch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hiwr_ev |=> latch_q == $past(wdata));
endmodule

// File: rtl/pcs_pc_core.sv
module pcs_pc_core
  import pcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  pc_sel_e         sel,
  input  logic [PC_W-1:0] imm,
  input  logic [PC_W-1:0] pop_data,
  input  logic [HI_W-1:0] hi_bits,
  input  logic [LO_W-1:0] alu,
  output logic [PC_W-1:0] pc_q
);
  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (sel)
      SEL_INC:   pc_d = next_seq(pc_q);
      SEL_POP:   pc_d = pop_data;
      SEL_CALL,
      SEL_JUMP:  pc_d = imm;
      SEL_LOWWR: pc_d = join_low(hi_bits, alu);
      default:   pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_HOLD |=> $stable(pc_q));
  p_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_INC && &pc_q) |=> pc_q == '0);
  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_JUMP || sel == SEL_CALL) |=> pc_q == $past(imm));
  p_lowwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_LOWWR |=> pc_q[PC_W-1:LO_W] == $past(hi_bits));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic            op_ljump,
  input  logic            op_lcall,
  input  logic            op_retw,
  input  logic            op_ret,
  input  logic            op_reti,
  input  logic [PC_W-1:0] imm_addr,
  input  logic [LO_W-1:0] alu_res,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_waddr,
  input  logic [RA_W-1:0] reg_raddr,
  output logic [PC_W-1:0] pc,
  output logic [LO_W-1:0] reg_rdata,
  output logic            gie_set
);
  logic            any_ret, push_ev, pop_ev, lowwr_ev;
  logic [LO_W-1:0] latch_q;
  logic [PC_W-1:0] pop_data;
  pc_sel_e         sel;

  assign any_ret = op_retw | op_ret | op_reti;
  assign pop_ev  = cyc_en & any_ret;
  assign push_ev = cyc_en & op_lcall & ~any_ret;

  always_comb begin
    if (!cyc_en)       sel = SEL_HOLD;
    else if (any_ret)  sel = SEL_POP;
    else if (op_lcall) sel = SEL_CALL;
    else if (op_ljump) sel = SEL_JUMP;
    else if (lowwr_ev) sel = SEL_LOWWR;
    else               sel = SEL_INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_set <= 1'b0;
    else        gie_set <= cyc_en & op_reti;
  end

  pcs_regport u_regs (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .wdata(alu_res), .reg_raddr(reg_raddr),
    .pc_low(pc[LO_W-1:0]), .latch_q(latch_q), .lowwr_ev(lowwr_ev),
    .reg_rdata(reg_rdata)
  );

  pcs_ret_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev),
    .push_data(next_seq(pc)), .top_data(pop_data)
  );

  pcs_pc_core u_core (
    .clk(clk), .rst_n(rst_n), .sel(sel), .imm(imm_addr),
    .pop_data(pop_data), .hi_bits(latch_q[HI_W-1:0]), .alu(alu_res),
    .pc_q(pc)
  );

  p_gie_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |-> $past(cyc_en && op_reti));
  p_gie_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && op_reti) |=> gie_set);
  p_ret_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |-> !push_ev);
  p_call_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (pop_ev |=> pc == $past(pc, 2) + PC_W'(1)));
endmodule

// File: tb/pc_stack_unit_tb_top.sv
module pc_stack_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cyc_en, op_ljump, op_lcall, op_retw, op_ret, op_reti, reg_we, gie_set;
  logic [9:0] imm_addr, pc;
  logic [7:0] alu_res, reg_waddr, reg_raddr, reg_rdata;

  pc_stack_unit dut_i (.*);

  int vectors = 0, errs = 0;
  int m_pc = 0, m_sp = 0, m_latch = 0;
  int m_stk[8];
  bit m_gie = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit ce, bit jmp, bit call, bit rw, bit r, bit ri,
                      bit we, int wa, int wd, int imm_v, int ra, string ftag);
    string t;
    int nsrc;
    @(negedge clk);
    cyc_en = ce; op_ljump = jmp; op_lcall = call; op_retw = rw; op_ret = r;
    op_reti = ri; reg_we = we; reg_waddr = 8'(wa); alu_res = 8'(wd);
    imm_addr = 10'(imm_v); reg_raddr = 8'(ra);
    nsrc = int'(jmp) + int'(call) + int'(rw) + int'(r) + int'(ri) + int'(we && wa == 2);
    if (!ce) t = "R2";
    else if (rw || r || ri) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; t = "R7";
    end else if (call) begin
      m_stk[m_sp] = (m_pc + 1) % 1024; m_sp = (m_sp + 1) % 8; m_pc = imm_v; t = "R4";
    end else if (jmp) begin
      m_pc = imm_v; t = "R3";
    end else if (we && wa == 2) begin
      m_pc = ((m_latch % 4) * 256) + wd; t = "R5";
    end else begin
      t = (m_pc == 1023) ? "R11" : "R2";
      m_pc = (m_pc + 1) % 1024;
    end
    if (ce && nsrc > 1) t = "R10";
    if (ftag != "") t = ftag;
    if (ce && we && wa == 10) m_latch = wd;
    m_gie = ce && ri;
    @(posedge clk);
    #1;
    chk(t, 32'(pc), 32'(m_pc));
    chk("R8", 32'(gie_set), 32'(m_gie));
    chk("R6", 32'(reg_rdata), (ra == 2) ? (m_pc % 256) : (ra == 10) ? m_latch : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    rst_n = 0; cyc_en = 0; op_ljump = 0; op_lcall = 0; op_retw = 0; op_ret = 0;
    op_reti = 0; reg_we = 0; reg_waddr = 0; alu_res = 0; imm_addr = 0; reg_raddr = 8'h0A;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(pc), 0);
    chk("R1", 32'(gie_set), 0);
    chk("R1", 32'(reg_rdata), 0);
    @(negedge clk); rst_n = 1;

    // R2 increment and hold
    for (int i = 0; i < 4; i++) step(1,0,0,0,0,0, 0,0,0, 0, 2, "");
    step(0,0,0,0,0,0, 0,0,0, 0, 2, "R2");
    // R6 latch write/readback, R5 low write
    step(1,0,0,0,0,0, 1,10,8'hA7, 0, 10, "R6");
    step(1,0,0,0,0,0, 1,2,8'h5C, 0, 2, "R5");
    // R11 wrap
    step(1,1,0,0,0,0, 0,0,0, 1022, 2, "R3");
    for (int i = 0; i < 3; i++) step(1,0,0,0,0,0, 0,0,0, 0, 2, "");
    // R9 nine nested calls then nine returns
    for (int i = 0; i < 9; i++) step(1,0,1,0,0,0, 0,0,0, 16*i+5, 2, "R4");
    for (int i = 0; i < 9; i++) step(1,0,0,i%3==0,i%3==1,i%3==2, 0,0,0, 0, 2, "R9");
    // R8 reti pulse, R10 collision
    step(1,0,1,0,0,1, 1,2,8'h11, 100, 10, "R10");
    step(1,1,1,0,0,0, 1,2,8'h22, 300, 2, "R10");

    for (int n = 0; n < 3000; n++) begin
      int ra_sel, wa_sel;
      bit ce, jmp, call, rw, r, ri, we;
      ce   = ($urandom % 10) != 0;
      jmp  = ($urandom % 12) == 0;
      call = ($urandom % 9) == 0;
      rw   = ($urandom % 25) == 0;
      r    = ($urandom % 25) == 0;
      ri   = ($urandom % 25) == 0;
      we   = ($urandom % 5) == 0;
      wa_sel = $urandom % 3;
      ra_sel = $urandom % 3;
      step(ce, jmp, call, rw, r, ri, we,
           (wa_sel == 0) ? 2 : (wa_sel == 1) ? 10 : int'($urandom % 256),
           int'($urandom % 256), int'($urandom % 1024),
           (ra_sel == 0) ? 2 : (ra_sel == 1) ? 10 : 7, "");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule